// File: doc/BRIEF.md
# Response Packet Assembler

This block builds response packets for a byte-wide transmit port. A request strobe starts a packet, and a select input picks the payload type. Every packet begins with a four-byte fixed header. The payload that follows is one of two things. It is either a complete frame of 32-bit words pulled from an upstream first-word-fall-through FIFO, or a 128-bit checksum word captured when the request is taken. Both payload sources are cut into bytes, most significant byte first.

Assembled bytes pass through a small internal output FIFO. They leave on a valid/ready byte stream, one byte per clock at full rate. A flag marks the final payload byte, and a one-cycle done pulse reports that the packet has fully left the block. A frame request waits until the upstream FIFO holds a whole frame, so a packet never stalls for lack of data once it has started.

Top module: `resp_pkt_asm`

## Requirements
- R1: Every packet begins with four header bytes, sent before any payload byte: 8'hA7, 8'h5E, 8'h3C, then a type byte. The type byte is 8'h01 for a frame payload and 8'h02 for a checksum payload.
- R2: A frame payload is 81 words taken in FIFO order, each word sent most significant byte first. That is 324 payload bytes, 328 bytes per packet, and exactly 81 pops of the frame FIFO.
- R3: A checksum payload is the 128-bit `csum_i` value captured in the cycle the request is taken, sent from bits 127:120 downward. That is 16 payload bytes and 20 per packet. The frame FIFO is not popped during a checksum packet.
- R4: `m_last_o` is high on the final payload byte of each packet and on no other byte.
- R5: A frame request (`req_i` high, `req_csum_i` low) is held off while `ff_count_i` is below 81. While held off, the block stays idle and reads nothing.
- R6: A request is ignored while `busy_o` is high. `busy_o` is high from the cycle after acceptance until `done_o` is pulsed.
- R7: `done_o` is high for exactly one cycle, the cycle after the final byte is accepted. `busy_o` is low in that same cycle.
- R8: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o`, `m_data_o` and `m_last_o` hold their values into the next cycle.
- R9: After reset, `m_valid_o`, `busy_o`, `done_o` and `ff_rd_o` are low.
- R10: With `m_ready_i` held high, a checksum packet completes with `done_o` no more than 24 cycles after the request is taken. This means one byte per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Packet request strobe |
| req_csum_i | input | 1 | Payload select: 1 checksum, 0 frame |
| csum_i | input | 128 | Checksum word, captured at acceptance |
| ff_count_i | input | 7 | Words held by the frame FIFO |
| ff_data_i | input | 32 | Head word of the frame FIFO (fall-through) |
| ff_rd_o | output | 1 | Pop the frame FIFO head |
| m_data_o | output | 8 | Output byte |
| m_valid_o | output | 1 | Output byte valid |
| m_ready_i | input | 1 | Output byte accepted when high with valid |
| m_last_o | output | 1 | Final payload byte |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle packet-complete pulse |

## Verification
The bench goes after several corner cases, each tied to a distinct fault:
- Byte order inside a word and inside the checksum: a reversed slice shows up as mismatching payload bytes.
- The frame hold-off at 80 versus 81 available words: an early start would pop words that are not yet present, and a late start would never begin.
- Requests raised mid-packet: a design that accepts them would emit a second header or consume frame words.
- Back-pressure patterns on the ready input: a design that drops or repeats bytes under stall fails the byte-count and last-flag checks.
- The checksum capture point: `csum_i` is changed after acceptance, so late sampling would corrupt the payload.

// File: rtl/resp_pkt_asm.sv
module resp_pkt_asm #(
  parameter int          WORD_W      = 32,
  parameter int          FRAME_WORDS = 81,
  parameter int          CSUM_W      = 128,
  parameter int          OF_DEPTH    = 8,
  parameter logic [23:0] HDR_TAG     = 24'hA75E3C,
  parameter logic [7:0]  TYPE_FRAME  = 8'h01,
  parameter logic [7:0]  TYPE_CSUM   = 8'h02,
  localparam int         CNT_W       = $clog2(FRAME_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_csum_i,
  input  logic [CSUM_W-1:0] csum_i,
  input  logic [CNT_W-1:0]  ff_count_i,
  input  logic [WORD_W-1:0] ff_data_i,
  output logic              ff_rd_o,
  output logic [7:0]        m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              m_last_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WB          = WORD_W / 8;
  localparam int BS_W        = $clog2(WB);
  localparam int FRAME_BYTES = FRAME_WORDS * WB;
  localparam int CSUM_BYTES  = CSUM_W / 8;
  localparam int MAX_BYTES   = (FRAME_BYTES > CSUM_BYTES) ? FRAME_BYTES : CSUM_BYTES;
  localparam int PC_W        = $clog2(MAX_BYTES + 1);
  localparam int OF_AW       = $clog2(OF_DEPTH);
  localparam int OCW         = OF_AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_DRAIN} st_t;

  st_t               st;
  logic              is_csum;
  logic [CSUM_W-1:0] csum_q;
  logic [1:0]        hcnt;
  logic [PC_W-1:0]   pcnt;
  logic              done_q;
  logic [8:0]        ofm [OF_DEPTH];
  logic [OF_AW:0]    wptr, rptr;

  logic [OF_AW:0]    of_cnt;
  logic              of_full, push, pop, accept, pay_last, push_last;
  logic [PC_W-1:0]   pay_end;
  logic [BS_W-1:0]   bsel;
  logic [WORD_W-1:0] fsh;
  logic [31:0]       hsh;
  logic [7:0]        push_byte;

  assign of_cnt    = wptr - rptr;
  assign of_full   = (of_cnt == OCW'(OF_DEPTH));
  assign m_valid_o = (of_cnt != '0);
  assign m_data_o  = ofm[rptr[OF_AW-1:0]][7:0];
  assign m_last_o  = ofm[rptr[OF_AW-1:0]][8] & m_valid_o;
  assign pop       = m_valid_o & m_ready_i;
  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_q;

  assign accept    = (st == S_IDLE) && req_i &&
                     (req_csum_i || (ff_count_i >= CNT_W'(FRAME_WORDS)));
  assign push      = ((st == S_HDR) || (st == S_PAY)) && !of_full;
  assign pay_end   = is_csum ? PC_W'(CSUM_BYTES - 1) : PC_W'(FRAME_BYTES - 1);
  assign pay_last  = (pcnt == pay_end);
  assign push_last = (st == S_PAY) && pay_last;
  assign bsel      = pcnt[BS_W-1:0];
  assign fsh       = ff_data_i << {bsel, 3'b000};
  assign hsh       = {HDR_TAG, (is_csum ? TYPE_CSUM : TYPE_FRAME)} << {hcnt, 3'b000};
  assign push_byte = (st == S_HDR) ? hsh[31:24] :
                     (is_csum ? csum_q[CSUM_W-1 -: 8] : fsh[WORD_W-1 -: 8]);
  assign ff_rd_o   = push && (st == S_PAY) && !is_csum && (bsel == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_csum <= 1'b0;
      csum_q  <= '0;
      hcnt    <= '0;
      pcnt    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= pop & m_last_o;
      case (st)
        S_IDLE: if (accept) begin
          is_csum <= req_csum_i;
          csum_q  <= csum_i;
          hcnt    <= '0;
          pcnt    <= '0;
          st      <= S_HDR;
        end
        S_HDR: if (push) begin
          hcnt <= hcnt + 2'd1;
          if (hcnt == 2'd3) st <= S_PAY;
        end
        S_PAY: if (push) begin
          pcnt <= pcnt + 1'b1;
          if (is_csum) csum_q <= csum_q << 8;
          if (pay_last) st <= S_DRAIN;
        end
        S_DRAIN: if (pop && m_last_o) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) ofm[wptr[OF_AW-1:0]] <= {push_last, push_byte};
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));
  a_r5_read_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    ff_rd_o |-> (ff_count_i != '0));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(m_valid_o && m_ready_i && m_last_o) && !busy_o));
  a_r3_no_pop_on_csum: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && is_csum) |-> !ff_rd_o);
  a_r6_one_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |=> busy_o || done_o);
endmodule

// File: tb/resp_pkt_asm_bench.sv
`timescale 1ns/1ps
module resp_pkt_asm_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, req_csum = 1'b0, ready = 1'b0;
  logic [127:0] csum = '0;
  logic [6:0]   ff_count;
  logic [31:0]  ff_data;
  logic         ff_rd, m_valid, m_last, busy, done;
  logic [7:0]   m_data;

  logic [31:0]  fq [256];
  int           head = 0, tail = 0;
  int           total = 0, bad = 0, cyc = 0;
  logic [7:0]   exp_b [328];
  int           exp_n;
  int           got_n, last_n, last_pos, done_n, lat;

  always #10 clk = ~clk;

  assign ff_count = 7'(tail - head);
  assign ff_data  = fq[head & 255];

  always @(posedge clk) if (ff_rd) head <= head + 1;

  resp_pkt_asm u_resp_pkt_asm (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_csum_i(req_csum), .csum_i(csum),
    .ff_count_i(ff_count), .ff_data_i(ff_data), .ff_rd_o(ff_rd),
    .m_data_o(m_data), .m_valid_o(m_valid), .m_ready_i(ready), .m_last_o(m_last),
    .busy_o(busy), .done_o(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fw(input int s, input int i);
    return {8'(s), 8'(i), 8'(~s), 8'(i * 7 + 3)};
  endfunction

  function automatic logic [127:0] cw(input int s);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[127 - 8*k -: 8] = 8'(s * 13 + k * 29 + 1);
    return r;
  endfunction

  task automatic load_frame(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      fq[tail & 255] = fw(s, i);
      tail++;
    end
  endtask

  task automatic build_exp(input bit c, input int s);
    logic [127:0] v;
    exp_b[0] = 8'hA7; exp_b[1] = 8'h5E; exp_b[2] = 8'h3C;
    exp_b[3] = c ? 8'h02 : 8'h01;
    if (c) begin
      v = cw(s);
      for (int k = 0; k < 16; k++) exp_b[4 + k] = v[127 - 8*k -: 8];
      exp_n = 20;
    end else begin
      for (int i = 0; i < 81; i++)
        for (int b = 0; b < 4; b++) exp_b[4 + 4*i + b] = fw(s, i)[31 - 8*b -: 8];
      exp_n = 328;
    end
  endtask

  task automatic fire(input bit c, input int s);
    @(negedge clk);
    req = 1'b1; req_csum = c; csum = cw(s);
    @(negedge clk);
    req = 1'b0; csum = '1;
  endtask

  task automatic collect(input logic [7:0] mask, input int inj, input string tag);
    int  mism = 0, first_bad = -1, cnt = 0;
    bit  fin = 0;
    got_n = 0; last_n = 0; last_pos = -1; done_n = 0; lat = 0;
    while (!fin && cnt < 3000) begin
      if (cnt > 0) @(negedge clk);
      cnt++;
      if (done) begin
        done_n++; fin = 1; lat = cnt;
        chk(!busy, {tag, " R7 busy low with done"}, busy, 0);
      end
      ready = mask[cnt % 8];
      if (cnt == inj)     begin req = 1'b1; req_csum = 1'b0; end
      if (cnt == inj + 1) req = 1'b0;
      #1;
      if (m_valid && ready) begin
        if (got_n < 328 && m_data !== exp_b[got_n]) begin
          mism++;
          if (first_bad < 0) first_bad = got_n;
        end
        if (m_last) begin last_n++; last_pos = got_n; end
        got_n++;
      end
    end
    req = 1'b0;
    @(negedge clk);
    chk(!done, {tag, " R7 done single cycle"}, done, 0);
    chk(got_n == exp_n, {tag, " R2 R3 byte count"}, got_n, exp_n);
    chk(mism == 0, {tag, " R1 R2 R3 byte content, first bad index"}, first_bad, -1);
    chk(last_n == 1 && last_pos == exp_n - 1, {tag, " R4 last position"}, last_pos, exp_n - 1);
    chk(done_n == 1, {tag, " R7 done seen"}, done_n, 1);
  endtask

  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hFF, 8'h11},
    {1'b0, 8'hFF, 8'h22},
    {1'b1, 8'h55, 8'h33},
    {1'b0, 8'hB3, 8'h44},
    {1'b1, 8'h01, 8'h55},
    {1'b0, 8'h7E, 8'h66}
  };

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    chk(!m_valid && !busy && !done && !ff_rd, "R9 reset outputs", {m_valid, busy, done, ff_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && !busy && !done, "R9 idle after reset", {m_valid, busy, done}, 0);

    for (int v = 0; v < 6; v++) begin
      logic c; logic [7:0] m, s;
      {c, m, s} = VEC[v];
      h0 = head;
      if (!c) load_frame(s, 81);
      build_exp(c, s);
      fire(c, s);
      collect(m, -10, $sformatf("vec%0d", v));
      chk(head - h0 == (c ? 0 : 81), "R2 R3 frame pops", head - h0, c ? 0 : 81);
    end

    // R5: 80 words held off
    h0 = head;
    load_frame(8'h77, 80);
    build_exp(1'b0, 8'h77);
    @(negedge clk);
    req = 1'b1; req_csum = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (busy || m_valid) break;
    end
    chk(!busy && !m_valid && head == h0, "R5 held off at 80 words", head - h0, 0);
    fq[tail & 255] = fw(8'h77, 80); tail++;
    @(negedge clk);
    req = 1'b0;
    chk(busy, "R5 start at 81 words", busy, 1);
    collect(8'hFF, -10, "holdoff");

    // R6: request during checksum packet ignored
    h0 = head;
    load_frame(8'h88, 81);
    build_exp(1'b1, 8'h99);
    fire(1'b1, 8'h99);
    collect(8'hFF, 5, "ignore");
    repeat (20) begin
      @(negedge clk);
      if (m_valid || busy) break;
    end
    chk(!m_valid && !busy, "R6 no second packet", m_valid, 0);
    chk(head == h0, "R6 frame FIFO untouched", head - h0, 0);

    // drain the loaded frame, then R10 throughput
    build_exp(1'b0, 8'h88);
    fire(1'b0, 8'h88);
    collect(8'hFF, -10, "drain");
    build_exp(1'b1, 8'hAB);
    fire(1'b1, 8'hAB);
    collect(8'hFF, -10, "rate");
    chk(lat <= 24 && lat >= 18, "R10 one byte per clock latency", lat, 22);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule